// File: doc/BRIEF.md
# Color Palette Host Port

This block is the processor-facing side of a 256-entry color lookup table with 24 bits per entry. A host reaches it over an 8-bit data bus with a chip enable, a write/read flag and a two-bit target select. One 8-bit address register points into the target storage, which is one of three kinds: the palette RAM, four overlay colors, or four 8-bit control registers. Each color is moved as three bytes in a fixed order: red, then green, then blue. A modulo-3 byte counter tracks which of the three bytes comes next.

After a blue byte, a palette or overlay access advances the address register. A control-register access leaves the address register alone, so software can read a register, change it and write it back at the same address. A separate read-only pixel port looks up palette entries by index for the display path. The control registers appear as plain outputs for that path.

One host access is taken on each clock edge while `host_cs` is high. Read data is registered and appears after that edge.

Top module: `palette_host_port`

## Requirements
- R1: After reset the address register and the byte counter are 0, `host_rdata` is 0, and all four overlay colors and all four control registers are 0.
- R2: With `reg_sel`=00, a write loads `host_wdata` into the address register and a read returns the address register. Either access returns the byte counter to red.
- R3: With `reg_sel`=01, three writes deliver red, green and blue. The entry at the current address becomes {red[23:16], green[15:8], blue[7:0]} on the blue write, and the address then increments, wrapping from FF to 00.
- R4: Red and green bytes are held aside, so a palette entry seen on the pixel port keeps its old value until the blue byte arrives.
- R5: With `reg_sel`=01, reads return red, green and blue in turn from a copy of the entry taken at the red read, and the address increments after blue.
- R6: With `reg_sel`=11 and address 0–3, overlay colors are written and read with the same byte order. The address increments after blue and wraps from 03 to 00.
- R7: With `reg_sel`=10, addresses 04, 05, 06 and 07 select the read mask, blink mask, command and test registers (`ctl_*` outputs). Such an access leaves the address register unchanged and returns the byte counter to red, even in the middle of a color sequence.
- R8: A write with `reg_sel`=11 and address above 03, or with `reg_sel`=10 and an address outside 04–07, changes no storage. A read in either case returns 0.
- R9: `pix_rdata` shows the palette entry at `pix_addr` one clock later. If a host commit hits the same entry in the same cycle, the old value is returned.
- R10: While `host_cs` is low, the address register, the byte counter and all storage hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs | input | 1 | Access enable, one access per clock |
| host_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | Target: 00 address, 01 palette, 10 control, 11 overlay |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| pix_addr | input | 8 | Pixel-side palette index |
| pix_rdata | output | 24 | Palette entry {R,G,B}, one cycle latency |
| ctl_read_mask | output | 8 | Control register at 04 |
| ctl_blink_mask | output | 8 | Control register at 05 |
| ctl_command | output | 8 | Control register at 06 |
| ctl_test | output | 8 | Control register at 07 |

## Verification
A byte counter that is out of step shifts every later color by one byte lane. The next committed palette entry then shows up wrong on the pixel port one cycle after its blue write, and the next read sequence returns bytes in the wrong lanes. A wrong address register lands the commit on a neighbouring entry, which the next read of the address register reveals at once. The bench therefore reads back the address after each sequence and looks up the entry through the pixel port. It also breaks sequences with control and address accesses and with idle cycles, to show that the counter restarts or holds as required.

// File: rtl/palette_host_port.sv
module palette_host_port #(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int OVL_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_cs,
  input  logic            host_wr,
  input  logic [1:0]      reg_sel,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic [AW-1:0]   pix_addr,
  output logic [3*DW-1:0] pix_rdata,
  output logic [DW-1:0]   ctl_read_mask,
  output logic [DW-1:0]   ctl_blink_mask,
  output logic [DW-1:0]   ctl_command,
  output logic [DW-1:0]   ctl_test
);
  localparam int CW    = 3 * DW;
  localparam int DEPTH = 1 << AW;
  localparam int OIW   = $clog2(OVL_N);
  localparam logic [1:0] SEL_ADDR = 2'b00;
  localparam logic [1:0] SEL_PAL  = 2'b01;
  localparam logic [1:0] SEL_CTL  = 2'b10;
  localparam logic [1:0] SEL_OVL  = 2'b11;
  localparam logic [AW-1:0] CTL_LO  = AW'(4);
  localparam logic [AW-1:0] CTL_HI  = AW'(7);
  localparam logic [AW-1:0] OVL_TOP = AW'(OVL_N - 1);

  logic [CW-1:0] pal_mem [DEPTH];
  logic [CW-1:0] ovl_q   [OVL_N];
  logic [DW-1:0] ctl_q   [4];
  logic [AW-1:0] addr_q;
  logic [1:0]    sub_q;
  logic [DW-1:0] stg_r, stg_g;
  logic [CW-1:0] hold_q;

  function automatic logic [DW-1:0] lane(input logic [CW-1:0] e, input logic [1:0] s);
    case (s)
      2'd0:    lane = e[3*DW-1:2*DW];
      2'd1:    lane = e[2*DW-1:DW];
      default: lane = e[DW-1:0];
    endcase
  endfunction

  wire ovl_ok  = addr_q <= OVL_TOP;
  wire ctl_ok  = (addr_q >= CTL_LO) && (addr_q <= CTL_HI);
  wire seq_acc = host_cs && reg_sel[0];
  wire is_blue = sub_q == 2'd2;
  wire pal_acc = host_cs && reg_sel == SEL_PAL;
  wire ovl_acc = host_cs && reg_sel == SEL_OVL && ovl_ok;
  wire ctl_acc = host_cs && reg_sel == SEL_CTL && ctl_ok;
  wire pal_commit = pal_acc && host_wr && is_blue;
  wire ovl_commit = ovl_acc && host_wr && is_blue;

  wire [OIW-1:0] ovl_idx = addr_q[OIW-1:0];
  wire [1:0]     ctl_idx = addr_q[1:0];
  wire [CW-1:0]  blue_word = {stg_r, stg_g, host_wdata};
  wire [CW-1:0]  seq_entry = (reg_sel == SEL_PAL) ? pal_mem[addr_q] : ovl_q[ovl_idx];

  logic [AW-1:0] addr_step;
  always_comb begin
    addr_step = addr_q;
    if (reg_sel == SEL_PAL)
      addr_step = addr_q + AW'(1);
    else if (ovl_ok)
      addr_step = (addr_q == OVL_TOP) ? '0 : addr_q + AW'(1);
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (reg_sel)
      SEL_ADDR: rd_next = addr_q;
      SEL_CTL:  rd_next = ctl_ok ? ctl_q[ctl_idx] : '0;
      default: begin
        if (reg_sel == SEL_PAL || ovl_ok)
          rd_next = (sub_q == 2'd0) ? lane(seq_entry, 2'd0) : lane(hold_q, sub_q);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      sub_q      <= '0;
      stg_r      <= '0;
      stg_g      <= '0;
      hold_q     <= '0;
      host_rdata <= '0;
    end else if (host_cs) begin
      if (!host_wr) host_rdata <= rd_next;
      if (reg_sel == SEL_ADDR) begin
        sub_q <= '0;
        if (host_wr) addr_q <= host_wdata;
      end else if (reg_sel == SEL_CTL) begin
        sub_q <= '0;
      end else if (seq_acc) begin
        sub_q <= is_blue ? 2'd0 : sub_q + 2'd1;
        if (is_blue) addr_q <= addr_step;
        if (host_wr && sub_q == 2'd0) stg_r <= host_wdata;
        if (host_wr && sub_q == 2'd1) stg_g <= host_wdata;
        if (!host_wr && sub_q == 2'd0) hold_q <= seq_entry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OVL_N; i++) ovl_q[i] <= '0;
      for (int i = 0; i < 4; i++) ctl_q[i] <= '0;
    end else begin
      if (ovl_commit) ovl_q[ovl_idx] <= blue_word;
      if (ctl_acc && host_wr) ctl_q[ctl_idx] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (pal_commit) pal_mem[addr_q] <= blue_word;
    pix_rdata <= pal_mem[pix_addr];
  end

  assign ctl_read_mask  = ctl_q[0];
  assign ctl_blink_mask = ctl_q[1];
  assign ctl_command    = ctl_q[2];
  assign ctl_test       = ctl_q[3];
endmodule

module palette_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_cs,
  input logic       host_wr,
  input logic [1:0] reg_sel,
  input logic [7:0] host_wdata,
  input logic [7:0] addr_q,
  input logic [1:0] sub_q
);
  // R2
  addr_sel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs && reg_sel == 2'b00 |=> sub_q == 2'd0);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs && host_wr && reg_sel == 2'b00 |=> addr_q == $past(host_wdata));
  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs && reg_sel == 2'b10 |=> addr_q == $past(addr_q) && sub_q == 2'd0);
  // R3
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q != 2'd3);
  // R3
  pal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs && reg_sel == 2'b01 && sub_q == 2'd2 |=> addr_q == 8'($past(addr_q) + 8'd1));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_cs |=> $stable(addr_q) && $stable(sub_q));
endmodule

bind palette_host_port palette_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
  .reg_sel(reg_sel), .host_wdata(host_wdata), .addr_q(addr_q), .sub_q(sub_q)
);

// File: tb/tb_palette_host_port.sv
module tb_palette_host_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic host_cs = 0, host_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] host_wdata = 0, pix_addr = 0;
  logic [7:0] host_rdata, ctl_read_mask, ctl_blink_mask, ctl_command, ctl_test;
  logic [23:0] pix_rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_host_port dut (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .reg_sel(reg_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_addr(pix_addr), .pix_rdata(pix_rdata),
    .ctl_read_mask(ctl_read_mask), .ctl_blink_mask(ctl_blink_mask),
    .ctl_command(ctl_command), .ctl_test(ctl_test)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] s, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    host_cs = 1; host_wr = w; reg_sel = s; host_wdata = d;
    @(negedge clk);
    host_cs = 0;
    q = host_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    logic [7:0] q;
    acc(1'b1, s, d, q);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] q);
    acc(1'b0, s, 8'h00, q);
  endtask

  task automatic wr_rgb(input logic [1:0] s, input logic [23:0] c);
    wr(s, c[23:16]); wr(s, c[15:8]); wr(s, c[7:0]);
  endtask

  task automatic rd_rgb(input logic [1:0] s, output logic [23:0] c);
    logic [7:0] r, g, b;
    rd(s, r); rd(s, g); rd(s, b);
    c = {r, g, b};
  endtask

  task automatic pix(input logic [7:0] a, output logic [23:0] c);
    @(negedge clk); pix_addr = a;
    @(negedge clk); c = pix_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] q;
    chk("R1 rdata", host_rdata, 0);
    chk("R1 ctl", {ctl_read_mask, ctl_blink_mask, ctl_command, ctl_test}, 0);
    rd(2'b00, q); chk("R1 addr", q, 0);
  endtask

  task automatic t_addr;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h5A); rd(2'b00, q); chk("R2 addr load", q, 8'h5A);
    wr(2'b00, 8'h10); wr(2'b01, 8'hE1); wr(2'b01, 8'hE2);
    wr(2'b00, 8'h10); wr_rgb(2'b01, 24'hC1C2C3);
    pix(8'h10, c); chk("R2 counter cleared", c, 24'hC1C2C3);
  endtask

  task automatic t_palette;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h20); wr_rgb(2'b01, 24'h112233);
    pix(8'h20, c); chk("R3 commit", c, 24'h112233);
    rd(2'b00, q); chk("R3 incr", q, 8'h21);
    wr(2'b00, 8'h20); wr(2'b01, 8'hAA); wr(2'b01, 8'hBB);
    pix(8'h20, c); chk("R4 partial hidden", c, 24'h112233);
    wr(2'b01, 8'hCC);
    pix(8'h20, c); chk("R4 blue commits", c, 24'hAABBCC);
    wr(2'b00, 8'hFF); wr_rgb(2'b01, 24'h0A0B0C);
    rd(2'b00, q); chk("R3 wrap", q, 8'h00);
    pix(8'hFF, c); chk("R3 entry FF", c, 24'h0A0B0C);
  endtask

  task automatic t_read;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h20); rd_rgb(2'b01, c); chk("R5 read order", c, 24'hAABBCC);
    rd(2'b00, q); chk("R5 incr", q, 8'h21);
    wr(2'b00, 8'h10); rd_rgb(2'b01, c); chk("R5 read 10", c, 24'hC1C2C3);
  endtask

  task automatic t_overlay;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h03); wr_rgb(2'b11, 24'h010203);
    rd(2'b00, q); chk("R6 wrap", q, 8'h00);
    wr_rgb(2'b11, 24'h405060);
    rd(2'b00, q); chk("R6 incr", q, 8'h01);
    wr(2'b00, 8'h03); rd_rgb(2'b11, c); chk("R6 ovl3", c, 24'h010203);
    rd_rgb(2'b11, c); chk("R6 ovl0", c, 24'h405060);
  endtask

  task automatic t_control;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h04); wr(2'b10, 8'h5F);
    rd(2'b00, q); chk("R7 addr held", q, 8'h04);
    chk("R7 read mask", ctl_read_mask, 8'h5F);
    wr(2'b00, 8'h05); wr(2'b10, 8'h6E); chk("R7 blink mask", ctl_blink_mask, 8'h6E);
    wr(2'b00, 8'h06); wr(2'b10, 8'h7D); chk("R7 command", ctl_command, 8'h7D);
    wr(2'b00, 8'h07); wr(2'b10, 8'h8C); chk("R7 test", ctl_test, 8'h8C);
    rd(2'b10, q); chk("R7 readback", q, 8'h8C);
    rd(2'b00, q); chk("R7 addr after read", q, 8'h07);
    wr(2'b00, 8'h04); wr(2'b01, 8'h77); wr(2'b10, 8'h99);
    chk("R7 mid-seq write", ctl_read_mask, 8'h99);
    wr_rgb(2'b01, 24'h313233);
    pix(8'h04, c); chk("R7 seq restarted", c, 24'h313233);
  endtask

  task automatic t_invalid;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h09); wr(2'b10, 8'hEE);
    chk("R8 ctl unchanged", {ctl_read_mask, ctl_blink_mask, ctl_command, ctl_test}, 32'h996E7D8C);
    rd(2'b10, q); chk("R8 ctl read", q, 0);
    wr(2'b00, 8'h05); wr_rgb(2'b11, 24'hDEADBE);
    wr(2'b00, 8'h05); rd(2'b11, q); chk("R8 ovl read", q, 0);
    wr(2'b00, 8'h03); rd_rgb(2'b11, c); chk("R8 ovl3 kept", c, 24'h010203);
  endtask

  task automatic t_pixel;
    logic [23:0] c;
    wr(2'b00, 8'h40); wr_rgb(2'b01, 24'h102030);
    wr(2'b00, 8'h40); wr(2'b01, 8'h44); wr(2'b01, 8'h55);
    @(negedge clk);
    host_cs = 1; host_wr = 1; reg_sel = 2'b01; host_wdata = 8'h66; pix_addr = 8'h40;
    @(negedge clk); host_cs = 0;
    chk("R9 same-cycle old", pix_rdata, 24'h102030);
    @(negedge clk);
    chk("R9 next cycle new", pix_rdata, 24'h445566);
    pix(8'h20, c); chk("R9 lookup", c, 24'hAABBCC);
  endtask

  task automatic t_idle;
    logic [7:0] q; logic [23:0] c;
    wr(2'b00, 8'h50); wr(2'b01, 8'h91);
    @(negedge clk); host_wr = 1; reg_sel = 2'b00; host_wdata = 8'hF0;
    repeat (5) @(negedge clk);
    wr(2'b01, 8'h92); wr(2'b01, 8'h93);
    pix(8'h50, c); chk("R10 counter held", c, 24'h919293);
    rd(2'b00, q); chk("R10 addr held", q, 8'h51);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_addr; t_palette; t_read; t_overlay;
    t_control; t_invalid; t_pixel; t_idle;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule